// File: doc/BRIEF.md
# Layer-First Rotating Route Selector

This block chooses the output port for every destination carried by one multicast packet arriving at one input of a three-dimensional mesh router. It is given the coordinates of the node it sits in and up to `NUM_DST` destination coordinates, each with a presence bit. One comparer per destination slot works out the next hop, and all slots are resolved in the same cycle. The result is a registered one-hot code over seven ports for each slot, together with a valid strobe.

A packet first changes layer. While a destination lies on another layer, that slot is sent Up or Down. Once the layer matches, the packet moves within the plane. If only one in-plane axis still has distance to cover, that axis is taken. If both X and Y still have distance to cover, a single stored bit decides between them. This bit is inverted on every such decision, so ties alternate between the two axes instead of always going X first. The slot whose coordinates equal the current node is delivered to Local.

When several slots tie in one request, the stored bit is used in ascending slot order and inverts once per tie. The next request then starts from the final value. Buffering, splitting of the packet and switching are done elsewhere.

Top module: `rot_route_calc`

## Requirements
- R1: After reset, `rsp_valid` is 0, every slot of `rsp_port` is 0, and the rotation bit is 0, so the first tie after reset goes along X.
- R2: For an active slot whose destination z differs from `cur_z`, the code is Down (bit 6) when `cur_z` is greater and Up (bit 5) when it is smaller, whatever the x and y values.
- R3: For an active slot with matching z where exactly one of x and y differs, that axis is taken: East (bit 1) when `cur_x` < destination x, West (bit 2) when greater, North (bit 3) when `cur_y` < destination y, South (bit 4) when greater.
- R4: For an active slot whose x, y and z all equal the current node, the code is Local (bit 0).
- R5: For an active slot with matching z where both x and y differ (a tie), the code is the X direction of R3 when the rotation bit is 0 and the Y direction of R3 when it is 1.
- R6: Each tie inverts the rotation bit. Ties in one request use it in ascending slot order, and the next request starts from the final value.
- R7: A request with no tie, and a cycle with `req_valid` low, leave the rotation bit unchanged.
- R8: A slot whose `req_mask` bit is 0 gives code 0 and does not use or invert the rotation bit.
- R9: `rsp_valid` and `rsp_port` appear exactly one clock after the request cycle. In cycles following a cycle with `req_valid` low, `rsp_valid` is 0 and all codes are 0.
- R10: While `rsp_valid` is 1, every active slot carries exactly one set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mask | input | NUM_DST | Per-slot presence bit |
| cur_x | input | XY_W | Current node x |
| cur_y | input | XY_W | Current node y |
| cur_z | input | Z_W | Current node layer |
| dst_x | input | NUM_DST*XY_W | Destination x per slot |
| dst_y | input | NUM_DST*XY_W | Destination y per slot |
| dst_z | input | NUM_DST*Z_W | Destination layer per slot |
| rsp_valid | output | 1 | Decision valid |
| rsp_port | output | NUM_DST*7 | One-hot port code per slot (bit0 Local, 1 East, 2 West, 3 North, 4 South, 5 Up, 6 Down) |

## Verification
Some properties are checked on every response cycle:
- a layer change takes priority over in-plane movement;
- a slot with only one differing in-plane axis takes that axis;
- a matching node is delivered to Local;
- every active slot carries exactly one bit;
- valid follows the request one cycle later;
- idle cycles give zero codes and leave the rotation bit alone.

The alternation itself can only be shown by the bench's scenarios. These cover the slot-order use of the rotation bit within one request, how the bit carries across requests and idle cycles, and the fact that masked slots skip it. Each scenario predicts every tie outcome from the count of earlier ties.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int PORT_N = 7;
  typedef logic [PORT_N-1:0] port_oh_t;
  localparam port_oh_t OH_LOCAL = 7'b0000001;
  localparam port_oh_t OH_EAST  = 7'b0000010;
  localparam port_oh_t OH_WEST  = 7'b0000100;
  localparam port_oh_t OH_NORTH = 7'b0001000;
  localparam port_oh_t OH_SOUTH = 7'b0010000;
  localparam port_oh_t OH_UP    = 7'b0100000;
  localparam port_oh_t OH_DOWN  = 7'b1000000;
endpackage

// File: rtl/rrc_rst_sync.sv
module rrc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/rrc_slot_cmp.sv
module rrc_slot_cmp
  import rrc_pkg::*;
#(
  parameter int XY_W = 2,
  parameter int Z_W  = 2
) (
  input  logic [XY_W-1:0] cur_x,
  input  logic [XY_W-1:0] cur_y,
  input  logic [Z_W-1:0]  cur_z,
  input  logic [XY_W-1:0] dst_x,
  input  logic [XY_W-1:0] dst_y,
  input  logic [Z_W-1:0]  dst_z,
  output port_oh_t        fixed_port,
  output logic            tie,
  output port_oh_t        x_port,
  output port_oh_t        y_port
);
  logic x_go, y_go;

  always_comb begin
    x_go   = (cur_x != dst_x);
    y_go   = (cur_y != dst_y);
    x_port = (cur_x > dst_x) ? OH_WEST  : OH_EAST;
    y_port = (cur_y > dst_y) ? OH_SOUTH : OH_NORTH;
    tie        = 1'b0;
    fixed_port = '0;
    if (cur_z > dst_z)      fixed_port = OH_DOWN;
    else if (cur_z < dst_z) fixed_port = OH_UP;
    else if (x_go && y_go)  tie        = 1'b1;
    else if (x_go)          fixed_port = x_port;
    else if (y_go)          fixed_port = y_port;
    else                    fixed_port = OH_LOCAL;
  end
endmodule

// File: rtl/rrc_tie_chain.sv
module rrc_tie_chain
  import rrc_pkg::*;
#(
  parameter int NUM_DST = 4
) (
  input  logic [NUM_DST-1:0]           active,
  input  logic [NUM_DST-1:0]           tie,
  input  logic [NUM_DST-1:0][PORT_N-1:0] fixed_port,
  input  logic [NUM_DST-1:0][PORT_N-1:0] x_port,
  input  logic [NUM_DST-1:0][PORT_N-1:0] y_port,
  input  logic                         flag_in,
  output logic [NUM_DST-1:0][PORT_N-1:0] sel_port,
  output logic                         flag_out
);
  always_comb begin
    logic run;
    run = flag_in;
    for (int i = 0; i < NUM_DST; i++) begin
      sel_port[i] = '0;
      if (active[i]) begin
        if (tie[i]) begin
          sel_port[i] = run ? y_port[i] : x_port[i];
          run = ~run;
        end else begin
          sel_port[i] = fixed_port[i];
        end
      end
    end
    flag_out = run;
  end
endmodule

// File: rtl/rot_route_calc.sv
module rot_route_calc
  import rrc_pkg::*;
#(
  parameter int NUM_DST = 4,
  parameter int XY_W    = 2,
  parameter int LAYERS  = 4,
  localparam int Z_W    = (LAYERS > 1) ? $clog2(LAYERS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic [NUM_DST-1:0]              req_mask,
  input  logic [XY_W-1:0]                 cur_x,
  input  logic [XY_W-1:0]                 cur_y,
  input  logic [Z_W-1:0]                  cur_z,
  input  logic [NUM_DST-1:0][XY_W-1:0]    dst_x,
  input  logic [NUM_DST-1:0][XY_W-1:0]    dst_y,
  input  logic [NUM_DST-1:0][Z_W-1:0]     dst_z,
  output logic                            rsp_valid,
  output logic [NUM_DST-1:0][PORT_N-1:0]  rsp_port
);
  logic rst_n_s;
  logic [NUM_DST-1:0]             tie_v;
  logic [NUM_DST-1:0][PORT_N-1:0] fixed_v, xp_v, yp_v, sel_v;
  logic [NUM_DST-1:0][PORT_N-1:0] port_d;
  logic flag_q, flag_d, flag_en, valid_d;

  rrc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  for (genvar g = 0; g < NUM_DST; g++) begin : g_slot
    rrc_slot_cmp #(.XY_W(XY_W), .Z_W(Z_W)) u_cmp (
      .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
      .dst_x(dst_x[g]), .dst_y(dst_y[g]), .dst_z(dst_z[g]),
      .fixed_port(fixed_v[g]), .tie(tie_v[g]),
      .x_port(xp_v[g]), .y_port(yp_v[g])
    );
  end

  rrc_tie_chain #(.NUM_DST(NUM_DST)) u_chain (
    .active(req_mask), .tie(tie_v), .fixed_port(fixed_v),
    .x_port(xp_v), .y_port(yp_v), .flag_in(flag_q),
    .sel_port(sel_v), .flag_out(flag_d)
  );

  always_comb begin
    valid_d = req_valid;
    flag_en = req_valid;
    port_d  = req_valid ? sel_v : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_valid <= 1'b0;
      rsp_port  <= '0;
      flag_q    <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_port  <= port_d;
      if (flag_en) flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/rot_route_calc_chk.sv
module rot_route_calc_chk
  import rrc_pkg::*;
#(
  parameter int NUM_DST = 4,
  parameter int XY_W    = 2,
  parameter int Z_W     = 2
) (
  input logic                            clk,
  input logic                            rst_n_s,
  input logic                            req_valid,
  input logic [NUM_DST-1:0]              req_mask,
  input logic [XY_W-1:0]                 cur_x,
  input logic [XY_W-1:0]                 cur_y,
  input logic [Z_W-1:0]                  cur_z,
  input logic [NUM_DST-1:0][XY_W-1:0]    dst_x,
  input logic [NUM_DST-1:0][XY_W-1:0]    dst_y,
  input logic [NUM_DST-1:0][Z_W-1:0]     dst_z,
  input logic                            rsp_valid,
  input logic [NUM_DST-1:0][PORT_N-1:0]  rsp_port,
  input logic                            flag_q
);
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid |=> rsp_valid);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |=> (!rsp_valid && rsp_port == '0));

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |=> $stable(flag_q));

  for (genvar g = 0; g < NUM_DST; g++) begin : g_chk
    p_one_bit_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
      rsp_valid |-> ($countones(rsp_port[g]) == ($past(req_mask[g]) ? 1 : 0)));

    p_z_first_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
      (rsp_valid && $past(req_mask[g] && (dst_z[g] != cur_z)))
        |-> (rsp_port[g] == OH_UP || rsp_port[g] == OH_DOWN));

    p_one_axis_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
      (rsp_valid && $past(req_mask[g] && (dst_z[g] == cur_z) &&
                          ((dst_x[g] == cur_x) != (dst_y[g] == cur_y))))
        |-> (rsp_port[g] == OH_EAST || rsp_port[g] == OH_WEST ||
             rsp_port[g] == OH_NORTH || rsp_port[g] == OH_SOUTH));

    p_local_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
      (rsp_valid && $past(req_mask[g] && (dst_z[g] == cur_z) &&
                          (dst_x[g] == cur_x) && (dst_y[g] == cur_y)))
        |-> (rsp_port[g] == OH_LOCAL));
  end
endmodule

bind rot_route_calc rot_route_calc_chk #(
  .NUM_DST(NUM_DST), .XY_W(XY_W), .Z_W(Z_W)
) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .req_valid(req_valid), .req_mask(req_mask),
  .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
  .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
  .rsp_valid(rsp_valid), .rsp_port(rsp_port), .flag_q(flag_q)
);

// File: tb/rot_route_calc_tb.sv
`timescale 1ns/1ps
module rot_route_calc_tb;
  localparam int ND = 4;
  localparam int XW = 2;
  localparam int ZW = 2;
  localparam logic [6:0] L = 7'b0000001, E = 7'b0000010, W = 7'b0000100,
                         N = 7'b0001000, S = 7'b0010000, U = 7'b0100000,
                         D = 7'b1000000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [ND-1:0] req_mask;
  logic [XW-1:0] cur_x, cur_y;
  logic [ZW-1:0] cur_z;
  logic [ND-1:0][XW-1:0] dst_x, dst_y;
  logic [ND-1:0][ZW-1:0] dst_z;
  logic rsp_valid;
  logic [ND-1:0][6:0] rsp_port;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rot_route_calc #(.NUM_DST(ND), .XY_W(XW), .LAYERS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mask(req_mask),
    .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
    .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
    .rsp_valid(rsp_valid), .rsp_port(rsp_port)
  );

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_cur(input int x, input int y, input int z);
    cur_x = XW'(x); cur_y = YW(y); cur_z = ZW'(z);
  endtask

  function automatic logic [XW-1:0] YW(input int v);
    return XW'(v);
  endfunction

  task automatic set_dst(input int s, input int x, input int y, input int z);
    dst_x[s] = XW'(x); dst_y[s] = XW'(y); dst_z[s] = ZW'(z);
  endtask

  // one request cycle; returns at the negedge after the registering edge
  task automatic fire(input logic [ND-1:0] m);
    @(negedge clk);
    req_mask  = m;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 valid", {6'b0, rsp_valid}, 7'd1);
  endtask

  task automatic t_reset();
    chk("R1 valid", {6'b0, rsp_valid}, 7'd0);
    for (int i = 0; i < ND; i++) chk("R1 port", rsp_port[i], 7'd0);
  endtask

  task automatic t_zfirst();
    set_cur(1, 2, 1);
    set_dst(0, 3, 0, 3); set_dst(1, 0, 0, 0);
    set_dst(2, 1, 2, 2); set_dst(3, 1, 2, 0);
    fire(4'b1111);
    chk("R2 up xy-tie", rsp_port[0], U);
    chk("R2 down", rsp_port[1], D);
    chk("R2 up", rsp_port[2], U);
    chk("R2 down2", rsp_port[3], D);
  endtask

  task automatic t_axis();
    set_cur(2, 2, 0);
    set_dst(0, 3, 2, 0); set_dst(1, 0, 2, 0);
    set_dst(2, 2, 3, 0); set_dst(3, 2, 0, 0);
    fire(4'b1111);
    chk("R3 east", rsp_port[0], E);
    chk("R3 west", rsp_port[1], W);
    chk("R3 north", rsp_port[2], N);
    chk("R3 south", rsp_port[3], S);
  endtask

  task automatic t_local();
    set_cur(1, 1, 2);
    set_dst(0, 1, 1, 2); set_dst(1, 1, 1, 1);
    set_dst(2, 1, 0, 2); set_dst(3, 1, 1, 2);
    fire(4'b1111);
    chk("R4 local", rsp_port[0], L);
    chk("R2 down same xy", rsp_port[1], D);
    chk("R3 south", rsp_port[2], S);
    chk("R4 local2", rsp_port[3], L);
  endtask

  // rotation bit is 0 here (no tie since reset): R1, R5, R6
  task automatic t_tie_order();
    set_cur(1, 1, 0);
    set_dst(0, 2, 2, 0); set_dst(1, 0, 0, 0);
    set_dst(2, 3, 0, 0); set_dst(3, 0, 3, 0);
    fire(4'b1111);
    chk("R5 R1 first tie X", rsp_port[0], E);
    chk("R6 second tie Y", rsp_port[1], S);
    chk("R6 third tie X", rsp_port[2], E);
    chk("R6 fourth tie Y", rsp_port[3], N);
  endtask

  // bit is 0 after four ties; one tie leaves 1, then idle and non-tie requests
  task automatic t_hold();
    set_cur(1, 1, 0);
    set_dst(0, 2, 2, 0);
    fire(4'b0001);
    chk("R6 carry start X", rsp_port[0], E);
    @(negedge clk);
    chk("R9 idle valid", {6'b0, rsp_valid}, 7'd0);
    chk("R9 idle port", rsp_port[0], 7'd0);
    repeat (3) @(negedge clk);
    set_dst(0, 3, 1, 0);
    fire(4'b0001);
    chk("R3 no-tie", rsp_port[0], E);
    set_dst(0, 2, 2, 0);
    fire(4'b0001);
    chk("R7 held bit picks Y", rsp_port[0], N);
  endtask

  // bit is 0; slot1 masked with a tie destination
  task automatic t_mask();
    set_cur(1, 1, 0);
    set_dst(0, 2, 2, 0); set_dst(1, 0, 0, 0);
    set_dst(2, 0, 0, 0); set_dst(3, 3, 3, 0);
    fire(4'b0101);
    chk("R8 slot0 X", rsp_port[0], E);
    chk("R8 masked zero", rsp_port[1], 7'd0);
    chk("R8 slot2 Y skip masked", rsp_port[2], S);
    chk("R8 masked zero3", rsp_port[3], 7'd0);
    fire(4'b0001);
    chk("R8 bit after two ties X", rsp_port[0], E);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mask = '0;
    cur_x = '0; cur_y = '0; cur_z = '0;
    dst_x = '0; dst_y = '0; dst_z = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_zfirst();
    t_axis();
    t_local();
    t_tie_order();
    t_hold();
    t_mask();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule